// File: doc/BRIEF.md
# Pi/4-Shift QPSK Burst Symbol Mapper

This block turns a 384 kbit/s serial transmit stream into signed in-phase and quadrature symbol values for a pulse-shaping filter further down the chain. It takes the bits in pairs, most significant bit first. Each pair advances a differential phase by an odd multiple of 45 degrees. Successive symbols therefore alternate between two four-point constellations that sit 45 degrees apart. The I and Q outputs update once per symbol, which is every second bit period.

A transmit window input marks which bits belong to a burst. While it is low, incoming bits are ignored and both outputs rest at zero. Each burst has a soft start and a soft end: the first two and last two symbols are emitted at reduced amplitude. The outputs lag the input data by a fixed number of whole symbols. A burst flag output is delayed by the same amount, so it frames exactly the symbols that carry the burst.

The bit clock has two sources, chosen by a select input. One is a 384 kHz clock applied directly. The other is a 3.84 MHz input divided by ten inside the block. The chosen bit clock is driven out for monitoring, and data should change on its falling edge. All logic runs on one system clock, which must be at least twice the fast input rate. Between two bursts the window must stay low for at least two bit periods.

Top module: `qpsk_burst_mapper`

## Requirements
- R1: During and right after reset, `i_out`, `q_out`, `burst_flag` and `bclk_mon` are all 0.
- R2: With `clk_sel` = 0, `bclk_mon` equals `bclk_in` delayed by one system clock. One data bit is taken on each of its rising edges.
- R3: With `clk_sel` = 1, `bclk_mon` is `fclk_in` divided by 10. It is high for 5 and low for 5 `fclk_in` periods. One data bit is taken on each of its rising edges.
- R4: Within a windowed pair, the first bit is the high bit of a dibit. The phase, in 45-degree units, steps +1 for 00, +3 for 01, −1 for 11 and −3 for 10. It starts from 0 at each burst, before the first symbol's step. The unscaled (I, Q) value for phase k is (cos, sin) with full axis 100 and diagonal 70: k=0 → (100,0), k=1 → (70,70), k=2 → (0,100), and so on around the circle.
- R5: Output = floor(value × s / 4). The scale s is 1 for the first symbol of a burst, 3 for the second, 1 for the last, 3 for the next-to-last, and 4 otherwise.
- R6: When a burst has three symbols or fewer, the ramp-up and ramp-down scales overlap, and the smaller of the two applies.
- R7: `burst_flag` first rises in bit period 13, counting the first windowed bit as period 0; with the default depth this is two times six plus one. Each symbol holds `burst_flag` high and I/Q constant for two bit periods, so I/Q and `burst_flag` change only on symbol boundaries.
- R8: While `burst_flag` is 0, I and Q are 0. Bits arriving while the window is low have no effect. A final bit left without a partner when the window falls is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 0: external bit clock, 1: divided fast clock |
| bclk_in | input | 1 | External 384 kHz bit clock |
| fclk_in | input | 1 | 3.84 MHz clock for the divide-by-10 source |
| tx_bit | input | 1 | Serial transmit data |
| tx_win | input | 1 | Transmit window, high for burst bits |
| bclk_mon | output | 1 | Selected bit clock, for monitoring and data timing |
| i_out | output | 8 | Signed in-phase symbol value |
| q_out | output | 8 | Signed quadrature symbol value |
| burst_flag | output | 1 | High while I/Q carry burst symbols |

## Verification
The ramp-up and the ramp-down can act on the same symbol. This happens in bursts of one, two and three symbols, where the first and last positions coincide or touch. The bench sends such bursts and checks that every symbol carries the smaller of the two scale factors, with values computed from the phase rule and the floor rounding. In longer bursts, the same per-symbol comparison confirms that the two ramps stay apart and that the symbols between them are emitted at full scale.

// File: rtl/qpsk_map_pkg.sv
package qpsk_map_pkg;

   // Phase in units of 45 degrees
   typedef logic [2:0] phase_t;

   // One symbol slot travelling through the latency line
   typedef struct packed {
      logic       ok;
      logic [1:0] dibit;
   } slot_t;

   // Gray dibit to phase increment
   function automatic phase_t phase_step(input logic [1:0] d);
      case (d)
         2'b00:   return 3'd1;
         2'b01:   return 3'd3;
         2'b11:   return 3'd7;
         default: return 3'd5;
      endcase
   endfunction

endpackage

// File: rtl/qmap_bitclk.sv
module qmap_bitclk #(
   parameter int DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_sel,
   input  logic bclk_in,
   input  logic fclk_in,
   output logic bclk_mon,
   output logic bit_tick
);
   localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int HALF = DIV / 2;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic          b_q, b_qq, f_q, f_qq;
   logic [CW-1:0] cnt, cnt_nx;
   logic          div_clk;
   logic          fast_edge, ext_edge;

   assign fast_edge = f_q & ~f_qq;
   assign ext_edge  = b_q & ~b_qq;
   assign cnt_nx    = (cnt == LAST) ? '0 : cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_q     <= 1'b0;
         b_qq    <= 1'b0;
         f_q     <= 1'b0;
         f_qq    <= 1'b0;
         cnt     <= LAST;
         div_clk <= 1'b0;
      end else begin
         b_q  <= bclk_in;
         b_qq <= b_q;
         f_q  <= fclk_in;
         f_qq <= f_q;
         if (fast_edge) begin
            cnt     <= cnt_nx;
            div_clk <= (32'(cnt_nx) < HALF);
         end
      end
   end

   assign bclk_mon = clk_sel ? div_clk : b_q;
   assign bit_tick = clk_sel ? (fast_edge && cnt == LAST) : ext_edge;

endmodule

// File: rtl/qmap_pairer.sv
module qmap_pairer
   import qpsk_map_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bit_tick,
   input  logic  tx_bit,
   input  logic  tx_win,
   output logic  sym_tick,
   output slot_t slot
);
   logic ph, msb, win_prev, burst_start;

   assign burst_start = tx_win && !win_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= 1'b0;
         msb      <= 1'b0;
         win_prev <= 1'b0;
      end else if (bit_tick) begin
         win_prev <= tx_win;
         if (burst_start || !ph) begin
            msb <= tx_bit;
            ph  <= 1'b1;
         end else begin
            ph  <= 1'b0;
         end
      end
   end

   assign sym_tick   = bit_tick && ph && !burst_start;
   assign slot.ok    = tx_win && win_prev;
   assign slot.dibit = {msb, tx_bit};

endmodule

// File: rtl/qmap_delay.sv
module qmap_delay
   import qpsk_map_pkg::*;
#(
   parameter int DEPTH = 6
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  shift,
   input  slot_t slot_in,
   output slot_t slot_out,
   output logic  ok_ahead1,
   output logic  ok_ahead2
);
   slot_t st [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            st[g] <= '0;
         else if (shift)
            st[g] <= (g == 0) ? slot_in : st[(g == 0) ? 0 : g - 1];
      end
   end

   assign slot_out  = st[DEPTH-1];
   assign ok_ahead1 = st[DEPTH-2].ok;
   assign ok_ahead2 = st[DEPTH-3].ok;

endmodule

// File: rtl/qmap_shaper.sv
module qmap_shaper
   import qpsk_map_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int AMPLITUDE = 100
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sym_tick,
   input  slot_t                    cur,
   input  logic                     ok_ahead1,
   input  logic                     ok_ahead2,
   output logic signed [DATA_W-1:0] i_out,
   output logic signed [DATA_W-1:0] q_out,
   output logic                     burst_flag
);
   localparam int DIAG = (AMPLITUDE * 181) / 256;
   localparam logic signed [DATA_W-1:0] A_P = DATA_W'(AMPLITUDE);
   localparam logic signed [DATA_W-1:0] D_P = DATA_W'(DIAG);

   function automatic logic signed [DATA_W-1:0] axis(input phase_t p);
      case (p)
         3'd0:    return A_P;
         3'd1:    return D_P;
         3'd3:    return -D_P;
         3'd4:    return -A_P;
         3'd5:    return -D_P;
         3'd7:    return D_P;
         default: return '0;
      endcase
   endfunction

   function automatic logic signed [DATA_W-1:0] scale(
      input logic signed [DATA_W-1:0] v, input logic [2:0] s);
      logic signed [DATA_W+2:0] prod;
      prod = (DATA_W+3)'(v) * (DATA_W+3)'($signed({1'b0, s}));
      return DATA_W'(prod >>> 2);
   endfunction

   phase_t     phase, ph_nx;
   logic [1:0] upcnt;
   logic       first;
   logic [2:0] s_up, s_dn, s_use;

   always_comb begin
      first = !burst_flag;
      ph_nx = (first ? 3'd0 : phase) + phase_step(cur.dibit);
      s_up  = first ? 3'd1 : ((upcnt == 2'd1) ? 3'd3 : 3'd4);
      s_dn  = !ok_ahead1 ? 3'd1 : (!ok_ahead2 ? 3'd3 : 3'd4);
      s_use = (s_up < s_dn) ? s_up : s_dn;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= '0;
         upcnt      <= '0;
         i_out      <= '0;
         q_out      <= '0;
         burst_flag <= 1'b0;
      end else if (sym_tick) begin
         if (cur.ok) begin
            phase      <= ph_nx;
            upcnt      <= first ? 2'd1 : 2'd2;
            i_out      <= scale(axis(ph_nx), s_use);
            q_out      <= scale(axis(ph_nx - 3'd2), s_use);
            burst_flag <= 1'b1;
         end else begin
            upcnt      <= '0;
            i_out      <= '0;
            q_out      <= '0;
            burst_flag <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/qpsk_burst_mapper.sv
module qpsk_burst_mapper
   import qpsk_map_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int AMPLITUDE    = 100,
   parameter int CLK_DIV      = 10,
   parameter int LATENCY_SYMS = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clk_sel,
   input  logic                     bclk_in,
   input  logic                     fclk_in,
   input  logic                     tx_bit,
   input  logic                     tx_win,
   output logic                     bclk_mon,
   output logic signed [DATA_W-1:0] i_out,
   output logic signed [DATA_W-1:0] q_out,
   output logic                     burst_flag
);
   if (LATENCY_SYMS < 3) begin : g_bad_latency
      $error("LATENCY_SYMS must be at least 3 for the ramp-down lookahead");
   end
   if (AMPLITUDE > (2 ** (DATA_W - 1)) - 1 || AMPLITUDE < 4) begin : g_bad_amp
      $error("AMPLITUDE must fit the signed output width and be at least 4");
   end
   if (CLK_DIV < 2) begin : g_bad_div
      $error("CLK_DIV must be at least 2");
   end

   logic  bit_tick, sym_tick;
   logic  ok_ahead1, ok_ahead2;
   slot_t slot_new, slot_out;

   qmap_bitclk #(.DIV(CLK_DIV)) u_clk (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .bclk_in(bclk_in),
      .fclk_in(fclk_in), .bclk_mon(bclk_mon), .bit_tick(bit_tick)
   );

   qmap_pairer u_pair (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_bit(tx_bit),
      .tx_win(tx_win), .sym_tick(sym_tick), .slot(slot_new)
   );

   qmap_delay #(.DEPTH(LATENCY_SYMS)) u_dly (
      .clk(clk), .rst_n(rst_n), .shift(sym_tick), .slot_in(slot_new),
      .slot_out(slot_out), .ok_ahead1(ok_ahead1), .ok_ahead2(ok_ahead2)
   );

   qmap_shaper #(.DATA_W(DATA_W), .AMPLITUDE(AMPLITUDE)) u_shp (
      .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .cur(slot_out),
      .ok_ahead1(ok_ahead1), .ok_ahead2(ok_ahead2),
      .i_out(i_out), .q_out(q_out), .burst_flag(burst_flag)
   );

endmodule

// File: rtl/qpsk_burst_mapper_chk.sv
module qpsk_burst_mapper_chk #(
   parameter int DATA_W    = 8,
   parameter int AMPLITUDE = 100
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     clk_sel,
   input logic                     bclk_in,
   input logic                     bclk_mon,
   input logic                     sym_tick,
   input logic signed [DATA_W-1:0] i_out,
   input logic signed [DATA_W-1:0] q_out,
   input logic                     burst_flag
);
   localparam int QTR = AMPLITUDE / 4;

   logic [1:0] settle;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) settle <= '0;
      else if (settle != 2'd3) settle <= settle + 2'd1;
   end

   // R2: monitor follows the external bit clock one cycle later
   p_mon_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (settle == 2'd3 && !clk_sel && !$past(clk_sel)) |-> bclk_mon == $past(bclk_in));

   // R7: outputs move only on symbol boundaries
   p_hold_symbol_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_tick |=> ($stable(i_out) && $stable(q_out) && $stable(burst_flag)));

   // R8: quiet outside the burst
   p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !burst_flag |-> (i_out == 0 && q_out == 0));

   // R4: never beyond full-scale amplitude
   p_amp_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(i_out) <= AMPLITUDE && $signed(i_out) >= -AMPLITUDE &&
       $signed(q_out) <= AMPLITUDE && $signed(q_out) >= -AMPLITUDE));

   // R5: first burst symbol is at quarter scale
   p_ramp_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_flag) |->
         ($signed(i_out) <= QTR && $signed(i_out) >= -QTR - 1 &&
          $signed(q_out) <= QTR && $signed(q_out) >= -QTR - 1));

endmodule

bind qpsk_burst_mapper qpsk_burst_mapper_chk #(.DATA_W(DATA_W), .AMPLITUDE(AMPLITUDE)) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .bclk_in(bclk_in),
   .bclk_mon(bclk_mon), .sym_tick(sym_tick), .i_out(i_out),
   .q_out(q_out), .burst_flag(burst_flag)
);

// File: tb/qpsk_burst_mapper_test.sv
`timescale 1ns/1ps
module qpsk_burst_mapper_test;
   localparam int LAT   = 6;
   localparam int AMP   = 100;
   localparam int DG    = 70;
   localparam int START = 4;

   logic clk = 1'b0, rst_n = 1'b0, clk_sel = 1'b0;
   logic bclk_in = 1'b0, fclk_in = 1'b0, tx_bit = 1'b0, tx_win = 1'b0;
   logic bclk_mon, burst_flag;
   logic signed [7:0] i_out, q_out;
   int   bcnt = 0;
   int   total = 0, bad = 0;
   logic bits [0:63];
   int   s_i [0:127], s_q [0:127], s_f [0:127];

   qpsk_burst_mapper uut (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .bclk_in(bclk_in),
      .fclk_in(fclk_in), .tx_bit(tx_bit), .tx_win(tx_win),
      .bclk_mon(bclk_mon), .i_out(i_out), .q_out(q_out), .burst_flag(burst_flag)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      fclk_in <= ~fclk_in;
      bcnt    <= (bcnt == 9) ? 0 : bcnt + 1;
      if (bcnt == 9) bclk_in <= ~bclk_in;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int tab(input int p);
      case (p & 7)
         0: return AMP;  1: return DG;  2: return 0;  3: return -DG;
         4: return -AMP; 5: return -DG; 6: return 0;  default: return DG;
      endcase
   endfunction

   // drives nb windowed bits from bits[], records outputs once per bit, checks them
   task automatic run_burst(input int nb, input string req);
      int len, nsym, p, stp, sc, up, dn, idx, ei, eq, quiet;
      len = START + nb + 2*LAT + 10;
      for (int k = 0; k < len; k++) begin
         @(negedge bclk_mon); @(negedge clk); #1;
         s_i[k] = int'(i_out); s_q[k] = int'(q_out); s_f[k] = int'(burst_flag);
         begin
            int b = k + 1;
            tx_win = (b >= START && b < START + nb);
            tx_bit = tx_win ? bits[b-START] : logic'(((b >> 1) ^ b) & 1);
         end
      end
      tx_win = 1'b0;
      nsym = nb / 2;
      quiet = 1;
      for (int k = 0; k <= START + 2*LAT; k++)
         if (s_f[k] != 0 || s_i[k] != 0 || s_q[k] != 0) quiet = 0;
      chk("R7", {req, " no output before latency"}, quiet, 1);
      chk("R7", {req, " flag low one bit before latency"}, s_f[START+2*LAT], 0);
      p = 0;
      for (int j = 0; j < nsym; j++) begin
         case ({bits[2*j], bits[2*j+1]})
            2'b00: stp = 1;  2'b01: stp = 3;  2'b11: stp = -1;  default: stp = -3;
         endcase
         p  = (p + stp + 8) % 8;
         up = (j == 0) ? 1 : ((j == 1) ? 3 : 4);
         dn = (j == nsym-1) ? 1 : ((j == nsym-2) ? 3 : 4);
         sc = (up < dn) ? up : dn;
         ei = (tab(p) * sc) >>> 2;
         eq = (tab(p - 2) * sc) >>> 2;
         idx = START + 2*LAT + 1 + 2*j;
         chk("R4/R5/R6", {req, " I symbol"}, s_i[idx], ei);
         chk("R4/R5/R6", {req, " Q symbol"}, s_q[idx], eq);
         chk("R7", {req, " flag in burst"}, s_f[idx], 1);
         chk("R7", {req, " I held second bit"}, s_i[idx+1], ei);
      end
      idx = START + 2*LAT + 1 + 2*nsym;
      chk("R8", {req, " flag low after burst"}, s_f[idx], 0);
      chk("R8", {req, " I zero after burst"}, s_i[idx], 0);
   endtask

   task automatic t_reset;
      @(negedge clk); #1;
      chk("R1", "i_out at reset", int'(i_out), 0);
      chk("R1", "q_out at reset", int'(q_out), 0);
      chk("R1", "burst_flag at reset", int'(burst_flag), 0);
      chk("R1", "bclk_mon at reset", int'(bclk_mon), 0);
   endtask

   task automatic t_mon_direct;
      logic prev;
      int   mism = 0;
      @(negedge clk); #1; prev = bclk_in;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk); #1;
         if (bclk_mon != prev) mism++;
         prev = bclk_in;
      end
      chk("R2", "monitor follows bclk_in", mism, 0);
   endtask

   task automatic t_mon_divided;
      logic pf, pm;
      int   rises = 0, high = 0, seen = 0;
      clk_sel = 1'b1;
      repeat (60) @(negedge clk);
      #1; pf = fclk_in; pm = bclk_mon;
      while (seen < 4) begin
         @(negedge clk); #1;
         if (fclk_in && !pf) begin
            rises++;
            if (bclk_mon) high++;
         end
         if (bclk_mon && !pm) begin
            if (seen > 0) begin
               chk("R3", "fast periods per bit", rises, 10);
               chk("R3", "fast periods high", high, 5);
            end
            seen++; rises = 0; high = 0;
         end
         pf = fclk_in; pm = bclk_mon;
      end
   endtask

   task automatic load(input logic [15:0] v, input int n);
      for (int k = 0; k < n; k++) bits[k] = v[15-k];
   endtask

   task automatic t_long_direct;
      clk_sel = 1'b0;
      repeat (60) @(negedge clk);
      load(16'b0001_1110_0000_1011, 16);
      run_burst(16, "R4 R5 R7 direct clock");
   endtask

   task automatic t_long_divided;
      clk_sel = 1'b1;
      repeat (60) @(negedge clk);
      load(16'b1011_0100_1110_0000, 12);
      run_burst(12, "R3 R4 divided clock");
   endtask

   task automatic t_short;
      clk_sel = 1'b0;
      repeat (60) @(negedge clk);
      load(16'b0100_0000_0000_0000, 2);  run_burst(2, "R6 one symbol");
      load(16'b1100_0000_0000_0000, 4);  run_burst(4, "R6 two symbols");
      load(16'b0110_0100_0000_0000, 6);  run_burst(6, "R6 three symbols");
   endtask

   task automatic t_odd;
      load(16'b0011_0101_0000_0000, 7);
      run_burst(7, "R8 odd bit count");
   endtask

   task automatic finish_run;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_mon_direct();
      t_long_direct();
      t_short();
      t_odd();
      t_mon_divided();
      t_long_divided();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

endmodule